// File: doc/BRIEF.md
# ADC Window Threshold Monitor

This block watches the stream of ADC conversion results. Each result arrives with a one-cycle valid strobe. The block compares the result with a programmable lower bound and a programmable upper bound. Software selects one of four conditions: below the lower bound, above the upper bound, inside the inclusive window, or outside the window. On every valid sample the block registers the outcome of the selected condition onto a monitor pin. When the outcome is true and the interrupt enable is set, it also sets a sticky interrupt flag.

Configuration uses a small write port with a 2-bit address. Address 0 holds the lower bound and address 1 holds the upper bound. Address 2 is the control word: mode in bits [1:0] and interrupt enable in bit 2. Writing address 3 with bit 0 set clears the interrupt flag. Samples and bounds are unsigned and `DATA_W` bits wide (12 by default).

Top module: `adc_window_monitor`

## Requirements
- R1: After reset `mon_o` is 0 and `irq_o` is 0. The lower bound resets to 0, the upper bound to all ones, the mode to 0 and the enable to 0.
- R2: In mode 0 the condition is true exactly when sample < lower bound.
- R3: In mode 1 the condition is true exactly when sample > upper bound.
- R4: In mode 2 the condition is true exactly when lower ≤ sample ≤ upper, and both bounds count as inside.
- R5: In mode 3 the condition is true exactly when sample < lower or sample > upper.
- R6: `mon_o` takes the condition value on the clock edge that samples `sample_valid_i` high, so it is visible one cycle after the strobe. In every other cycle it holds its value.
- R7: `irq_o` is set on the edge that captures a valid sample whose condition is true while the enable (control bit 2) is 1. Once set, it stays set until it is cleared.
- R8: A write to address 3 with data bit 0 = 1 clears `irq_o`. Such a write with bit 0 = 0 has no effect. If a clear and a set happen in the same cycle, the set wins.
- R9: While the enable is 0, no sample sets `irq_o`, and `mon_o` still follows the condition.
- R10: When lower > upper, mode 2 is never true, and mode 3 still follows its formula.
- R11: A configuration write takes effect from the next cycle on. A sample presented in the same cycle as the write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | ADC result |
| sample_valid_i | input | 1 | One-cycle strobe marking a new result |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 lower, 1 upper, 2 control, 3 clear |
| wr_data_i | input | DATA_W | Write data |
| mon_o | output | 1 | Registered condition result |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions run on every cycle. They check that the monitor pin holds between strobes. They check that the flag rises only after an enabled valid sample and falls only after a clear write with bit 0 set. They check that the flag cannot rise while the enable is off, and that an inverted window never reports inside. Several behaviours can only be shown by the bench scenarios: the exact values each mode produces at the bound edges, the rule that a set beats a clear in the same cycle, and the rule that a sample arriving alongside a write still sees the old settings.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  typedef enum logic [1:0] {
    MODE_BELOW   = 2'd0,
    MODE_ABOVE   = 2'd1,
    MODE_INSIDE  = 2'd2,
    MODE_OUTSIDE = 2'd3
  } win_mode_e;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_CLR = 2'd3;

  localparam int unsigned CTL_EN_BIT = 2;
endpackage

// File: rtl/adc_win_cfg.sv
module adc_win_cfg
  import adc_win_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output win_mode_e         mode_o,
  output logic              irq_en_o,
  output logic              clr_o
);
  logic [DATA_W-1:0] lo_q, hi_q;
  win_mode_e         mode_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '1;
      mode_q <= MODE_BELOW;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_LO:  lo_q <= wr_data_i;
        ADDR_HI:  hi_q <= wr_data_i;
        ADDR_CTL: begin
          mode_q <= win_mode_e'(wr_data_i[1:0]);
          en_q   <= wr_data_i[CTL_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign mode_o   = mode_q;
  assign irq_en_o = en_q;
  assign clr_o    = wr_en_i && (wr_addr_i == ADDR_CLR) && wr_data_i[0];
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
  import adc_win_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  win_mode_e         mode_i,
  output logic              hit_o
);
  logic below, above;

  assign below = sample_i < lo_i;
  assign above = sample_i > hi_i;

  // inside is the complement of outside, so an inverted window never yields inside
  always_comb begin
    unique case (mode_i)
      MODE_BELOW:   hit_o = below;
      MODE_ABOVE:   hit_o = above;
      MODE_INSIDE:  hit_o = !(below || above);
      MODE_OUTSIDE: hit_o = below || above;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_win_out.sv
module adc_win_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hit_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic mon_o,
  output logic irq_o
);
  logic mon_q, irq_q, set;

  assign set = valid_i && hit_i && irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (valid_i) mon_q <= hit_i;
      if (set)        irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign mon_o = mon_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adc_win_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mon_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] lo, hi;
  win_mode_e         mode;
  logic              irq_en, clr, hit;

  adc_win_cfg #(.DATA_W(DATA_W)) cfg_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .lo_o(lo), .hi_o(hi), .mode_o(mode), .irq_en_o(irq_en), .clr_o(clr)
  );

  adc_win_cmp #(.DATA_W(DATA_W)) cmp_i (
    .sample_i, .lo_i(lo), .hi_i(hi), .mode_i(mode), .hit_o(hit)
  );

  adc_win_out out_i (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .hit_i(hit),
    .irq_en_i(irq_en), .clr_i(clr), .mon_o, .irq_o
  );
endmodule

// File: rtl/adc_window_monitor_chk.sv
module adc_window_monitor_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] lo,
  input logic [DATA_W-1:0] hi,
  input logic [1:0]        mode,
  input logic              irq_en,
  input logic              mon_o,
  input logic              irq_o
);
  assert_mon_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(mon_o));

  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(sample_valid_i && irq_en));

  assert_irq_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0]));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en && !irq_o) |=> !irq_o);

  assert_inverted_inside_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && mode == 2'd2 && lo > hi) |=> !mon_o);
endmodule

bind adc_window_monitor adc_window_monitor_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .lo(lo), .hi(hi), .mode(mode), .irq_en(irq_en),
  .mon_o(mon_o), .irq_o(irq_o)
);

// File: tb/adc_window_monitor_tb_top.sv
module adc_window_monitor_tb_top;
  localparam int unsigned DW = 12;
  localparam int unsigned NV = 16;

  // {mode, lo, hi, sample, expected}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 12'd100, 12'd200, 12'd99,   1'b1},  // R2
    {2'd0, 12'd100, 12'd200, 12'd100,  1'b0},  // R2
    {2'd0, 12'd0,   12'd200, 12'd0,    1'b0},  // R2
    {2'd1, 12'd100, 12'd200, 12'd200,  1'b0},  // R3
    {2'd1, 12'd100, 12'd200, 12'd201,  1'b1},  // R3
    {2'd1, 12'd0,   12'd4095,12'd4095, 1'b0},  // R3
    {2'd2, 12'd100, 12'd200, 12'd100,  1'b1},  // R4
    {2'd2, 12'd100, 12'd200, 12'd200,  1'b1},  // R4
    {2'd2, 12'd100, 12'd200, 12'd99,   1'b0},  // R4
    {2'd2, 12'd100, 12'd200, 12'd201,  1'b0},  // R4
    {2'd3, 12'd100, 12'd200, 12'd99,   1'b1},  // R5
    {2'd3, 12'd100, 12'd200, 12'd150,  1'b0},  // R5
    {2'd3, 12'd100, 12'd200, 12'd201,  1'b1},  // R5
    {2'd2, 12'd300, 12'd200, 12'd250,  1'b0},  // R10
    {2'd3, 12'd300, 12'd200, 12'd250,  1'b1},  // R10
    {2'd2, 12'd300, 12'd200, 12'd300,  1'b0}   // R10
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          sample_valid_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          mon_o, irq_o;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_window_monitor #(.DATA_W(DW)) dut_i (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .mon_o, .irq_o
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic smp(input logic [DW-1:0] s);
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_i = s;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 mon", mon_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
    rst_ni = 1'b1;
    // R1: reset bounds 0..max, mode 0: sample 0 is not below 0
    smp(12'd0);
    check("R1 default bounds", mon_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][36:25]);
      wr(2'd1, VEC[i][24:13]);
      wr(2'd2, {9'd0, 1'b1, VEC[i][38:37]});
      wr(2'd3, 12'd1);
      smp(VEC[i][12:1]);
      check($sformatf("R2-5/R10 vec%0d mon", i), mon_o, VEC[i][0]);
      check($sformatf("R7 vec%0d irq", i), irq_o, VEC[i][0]);
    end

    // R6: hold between strobes
    wr(2'd0, 12'd100); wr(2'd1, 12'd200); wr(2'd2, 12'h4); // below, enabled
    smp(12'd10);
    check("R6 strobe", mon_o, 1'b1);
    sample_i = 12'd150;
    repeat (4) @(negedge clk_i);
    check("R6 hold", mon_o, 1'b1);
    // R7: sticky after a false sample
    smp(12'd150);
    check("R7 sticky mon", mon_o, 1'b0);
    check("R7 sticky irq", irq_o, 1'b1);
    // R8: clear with bit0=0 ignored, then real clear
    wr(2'd3, 12'd2);
    check("R8 no clear", irq_o, 1'b1);
    wr(2'd3, 12'd1);
    check("R8 clear", irq_o, 1'b0);
    // R8: set wins over clear
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 12'd1;
    sample_valid_i = 1'b1; sample_i = 12'd5;
    @(negedge clk_i);
    wr_en_i = 1'b0; sample_valid_i = 1'b0;
    check("R8 set wins", irq_o, 1'b1);
    wr(2'd3, 12'd1);
    // R9: disabled
    wr(2'd2, 12'h0);
    smp(12'd5);
    check("R9 mon follows", mon_o, 1'b1);
    check("R9 no irq", irq_o, 1'b0);
    // R11: sample alongside write uses old lower bound (100)
    smp(12'd150);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 12'd300;
    sample_valid_i = 1'b1; sample_i = 12'd150;
    @(negedge clk_i);
    wr_en_i = 1'b0; sample_valid_i = 1'b0;
    check("R11 old setting", mon_o, 1'b0);
    smp(12'd150);
    check("R11 new setting", mon_o, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule